// File: doc/BRIEF.md
# Write-Through Valid/Invalid Snooping Line Controller

This block keeps coherence state for a small direct-mapped cache whose writes always go straight through to memory and whose write misses never allocate a line. Each line carries a single valid bit and a tag. Processor reads that find a valid line with a matching tag finish in the same cycle without touching the bus. A read that misses first requests the bus and waits for the grant. It then waits for the transfer to complete, and the returned line becomes valid. Every processor write, hit or miss, becomes a bus write.

Several such controllers sit on one shared snooping bus. Each watches the transactions that the bus broadcasts on its snoop port. When another agent writes an address whose line is held valid locally, the local copy is dropped. Every transaction carries the requester's ID, so a controller ignores its own traffic. When a snoop kill and a processor lookup land in the same cycle, the snoop takes effect first. The data array, memory and bus arbitration live outside this block.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: A processor read (cpu_req_wr=0) whose line is valid with a matching tag asserts cpu_req_rdy and cpu_hit in the request cycle and starts no bus transaction.
- R2: A processor read that misses raises bus_req with bus_wr=0 and bus_addr equal to the request address, completes (cpu_req_rdy) in the cycle bus_done is high, and leaves the line valid so the next read of that address hits.
- R3: Every processor write (cpu_req_wr=1) raises bus_req with bus_wr=1, bus_addr equal to the request address and bus_id equal to the local ID, whether the line is valid or not.
- R4: A write to an invalid line, or to the same index with a different tag, does not allocate: a following read of that address misses.
- R5: A write to a valid matching line keeps it valid and pulses cpu_wr_upd with cpu_req_rdy; a following read hits.
- R6: A snooped write (snp_vld=1, snp_wr=1) from another ID whose address matches a valid line makes that line invalid; a snooped write to the same index with another tag leaves it valid.
- R7: Snooped transactions carrying the local ID, and snooped reads (snp_wr=0), change no line state.
- R8: While a transaction is pending, cpu_req_rdy stays low and bus_req stays high until bus_gnt is seen; a bus_done before the grant is ignored.
- R9: Reset clears every valid bit, so the first read of any address misses.
- R10: A snoop kill and a processor read of the same line in the same cycle resolve snoop first: the read misses and goes to the bus.
- R11: The address splits as index = low IDX_W bits and tag = the remaining upper bits; a hit needs both a valid bit and a tag match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_vld | input | 1 | Processor request present; held with its fields until cpu_req_rdy |
| cpu_req_wr | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Request address |
| cpu_req_rdy | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Read completed locally without a bus transaction |
| cpu_wr_upd | output | 1 | Write completing on a valid line: local copy is to be updated |
| bus_req | output | 1 | Bus request, held until grant |
| bus_wr | output | 1 | Transaction kind: 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Transaction address |
| bus_id | output | ID_W | Local requester ID |
| bus_gnt | input | 1 | Bus grant for this controller |
| bus_done | input | 1 | Granted transaction finished (read data returned / write accepted) |
| snp_vld | input | 1 | A bus transaction is being broadcast |
| snp_wr | input | 1 | Broadcast transaction is a write |
| snp_addr | input | ADDR_W | Broadcast address |
| snp_id | input | ID_W | Requester ID of the broadcast transaction |

## Verification
On every cycle the checker confirms that a local hit starts no bus traffic. It also confirms that a write always reaches the bus, that fills set and snoop kills clear the indexed valid bit, and that own-ID and read snoops never kill. It further checks that the request stays held without a ready before the grant, that a same-cycle kill turns a would-be hit into a miss, and that reset clears all lines. The end-to-end effects need the bench's scenarios with a second controller on a modelled bus: a write miss leaving a later read missing, and a peer write forcing a refetch. So do the exact transaction address and kind and the tag-aliasing cases, all compared against a bench-side line model.

// File: rtl/wtsc_pkg.sv
package wtsc_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ARB  = 2'd1,
    SQ_XFER = 2'd2
  } seq_st_t;
endpackage

// File: rtl/wtsc_tag_array.sv
module wtsc_tag_array #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic [IDX_W-1:0] sn_idx,
  input  logic [TAG_W-1:0] sn_tag,
  input  logic             sn_en,
  output logic             sn_kill,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  output logic [(1<<IDX_W)-1:0] line_vld
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_w [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic             fill_me;
    logic             kill_me;

    assign fill_me = fill_en && (fill_idx == IDX_W'(g));
    assign kill_me = sn_kill && (sn_idx == IDX_W'(g));

    // fill beats kill on the same line (a single bus cannot produce both)
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       v_q <= 1'b0;
      else if (fill_me) v_q <= 1'b1;
      else if (kill_me) v_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (fill_me) t_q <= fill_tag;
    end

    assign line_vld[g] = v_q;
    assign tag_w[g]    = t_q;
  end

  assign lk_hit  = line_vld[lk_idx] && (tag_w[lk_idx] == lk_tag);
  assign sn_kill = sn_en && line_vld[sn_idx] && (tag_w[sn_idx] == sn_tag);
endmodule

// File: rtl/wtsc_bus_seq.sv
module wtsc_bus_seq
  import wtsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bus_gnt,
  input  logic bus_done,
  output logic idle,
  output logic bus_req,
  output logic xfer_done
);
  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (start)    st_d = SQ_ARB;
      SQ_ARB:  if (bus_gnt)  st_d = SQ_XFER;
      SQ_XFER: if (bus_done) st_d = SQ_IDLE;
      default:               st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign idle      = (st_q == SQ_IDLE);
  assign bus_req   = (st_q == SQ_ARB);
  assign xfer_done = (st_q == SQ_XFER) && bus_done;
endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_vld,
  input  logic              cpu_req_wr,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_req_rdy,
  output logic              cpu_hit,
  output logic              cpu_wr_upd,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [ID_W-1:0]   bus_id,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic              snp_vld,
  input  logic              snp_wr,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam logic [ID_W-1:0] LOCAL_ID = ID_W'(MY_ID);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  // named internal events
  logic              fsm_idle;
  logic              xfer_done;
  logic              start;
  logic              lk_hit;
  logic              lk_live;
  logic              rd_hit;
  logic              sn_en;
  logic              snp_kill;
  logic [IDX_W-1:0]  snp_idx;
  logic [IDX_W-1:0]  lk_idx;
  logic              fill_en;
  logic [IDX_W-1:0]  fill_idx;
  logic [LINES-1:0]  line_vld;
  logic [ADDR_W-1:0] cur_addr;
  logic              lat_wr;
  logic [ADDR_W-1:0] lat_addr;

  // capture the request when it goes to the bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_wr   <= 1'b0;
      lat_addr <= '0;
    end else if (start) begin
      lat_wr   <= cpu_req_wr;
      lat_addr <= cpu_req_addr;
    end
  end

  assign cur_addr = fsm_idle ? cpu_req_addr : lat_addr;
  assign lk_idx   = idx_of(cur_addr);
  assign snp_idx  = idx_of(snp_addr);

  // only foreign writes can kill a line
  assign sn_en   = snp_vld && snp_wr && (snp_id != LOCAL_ID);
  // snoop first: a line being killed this cycle no longer counts
  assign lk_live = lk_hit && !(snp_kill && (snp_idx == lk_idx));
  assign rd_hit  = fsm_idle && cpu_req_vld && !cpu_req_wr && lk_live;
  assign start   = fsm_idle && cpu_req_vld && !rd_hit;

  assign fill_en  = xfer_done && !lat_wr;
  assign fill_idx = idx_of(lat_addr);

  wtsc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (lk_idx),
    .lk_tag   (tag_of(cur_addr)),
    .lk_hit   (lk_hit),
    .sn_idx   (snp_idx),
    .sn_tag   (tag_of(snp_addr)),
    .sn_en    (sn_en),
    .sn_kill  (snp_kill),
    .fill_en  (fill_en),
    .fill_idx (fill_idx),
    .fill_tag (tag_of(lat_addr)),
    .line_vld (line_vld)
  );

  wtsc_bus_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bus_gnt   (bus_gnt),
    .bus_done  (bus_done),
    .idle      (fsm_idle),
    .bus_req   (bus_req),
    .xfer_done (xfer_done)
  );

  assign cpu_req_rdy = rd_hit || xfer_done;
  assign cpu_hit     = rd_hit;
  assign cpu_wr_upd  = xfer_done && lat_wr && lk_live;
  assign bus_wr      = lat_wr;
  assign bus_addr    = lat_addr;
  assign bus_id      = LOCAL_ID;
endmodule

// File: rtl/wtsc_chk.sv
module wtsc_chk #(
  parameter int IDX_W = 3,
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_req_vld,
  input logic                  cpu_req_wr,
  input logic                  cpu_req_rdy,
  input logic                  cpu_hit,
  input logic                  cpu_wr_upd,
  input logic                  bus_req,
  input logic                  bus_wr,
  input logic                  bus_gnt,
  input logic                  snp_vld,
  input logic                  snp_wr,
  input logic [ID_W-1:0]       snp_id,
  input logic                  fsm_idle,
  input logic                  snp_kill,
  input logic [IDX_W-1:0]      snp_idx,
  input logic [IDX_W-1:0]      lk_idx,
  input logic                  fill_en,
  input logic [IDX_W-1:0]      fill_idx,
  input logic [(1<<IDX_W)-1:0] line_vld
);
  // R1: a local hit starts no bus transaction
  p_hit_no_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |=> !bus_req);

  // R2: a fill leaves its line valid
  p_fill_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> line_vld[$past(fill_idx)]);

  // R3: every write accepted in idle goes out as a bus write
  p_write_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && cpu_req_vld && cpu_req_wr) |=> (bus_req && bus_wr));

  // R4: completing a write never changes line state by itself
  p_no_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_rdy && cpu_req_wr && !snp_kill && !fill_en) |=> $stable(line_vld));

  // R5: the update strobe only accompanies a completing write
  p_upd_with_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_upd |-> (cpu_req_rdy && cpu_req_wr && !cpu_hit));

  // R6: a kill clears its line
  p_kill_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_kill && !fill_en) |=> !line_vld[$past(snp_idx)]);

  // R7: own-ID or read snoops never kill
  p_own_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_vld && (!snp_wr || snp_id == ID_W'(MY_ID))) |-> !snp_kill);

  // R8: request held until grant, no completion while requesting
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);
  p_no_rdy_arb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_req_rdy);

  // R9: reset empties every line
  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |=> (line_vld == '0));

  // R10: a same-cycle kill of the looked-up line prevents a hit
  p_snoop_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_kill && fsm_idle && snp_idx == lk_idx) |-> !cpu_hit);
endmodule

bind wt_snoop_ctrl wtsc_chk #(.IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_req_vld (cpu_req_vld),
  .cpu_req_wr  (cpu_req_wr),
  .cpu_req_rdy (cpu_req_rdy),
  .cpu_hit     (cpu_hit),
  .cpu_wr_upd  (cpu_wr_upd),
  .bus_req     (bus_req),
  .bus_wr      (bus_wr),
  .bus_gnt     (bus_gnt),
  .snp_vld     (snp_vld),
  .snp_wr      (snp_wr),
  .snp_id      (snp_id),
  .fsm_idle    (fsm_idle),
  .snp_kill    (snp_kill),
  .snp_idx     (snp_idx),
  .lk_idx      (lk_idx),
  .fill_en     (fill_en),
  .fill_idx    (fill_idx),
  .line_vld    (line_vld)
);

// File: tb/tb_wt_snoop_ctrl.sv
`timescale 1ns/1ps
module tb_wt_snoop_ctrl;
  localparam int AW = 8;
  localparam int IW = 3;
  localparam int DW = 2;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // per-agent CPU side: index 0 = dut (ID 0), 1 = peer (ID 1)
  logic          c_vld [2];
  logic          c_wr  [2];
  logic [AW-1:0] c_addr[2];
  logic          c_rdy [2];
  logic          c_hit [2];
  logic          c_upd [2];
  logic          b_req [2];
  logic          b_wr  [2];
  logic [AW-1:0] b_addr[2];
  logic [DW-1:0] b_id  [2];
  logic          b_gnt [2];
  logic          b_done[2];
  logic          s_vld, s_wr;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_id;

  wt_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .ID_W(DW), .MY_ID(0)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_vld(c_vld[0]), .cpu_req_wr(c_wr[0]), .cpu_req_addr(c_addr[0]),
    .cpu_req_rdy(c_rdy[0]), .cpu_hit(c_hit[0]), .cpu_wr_upd(c_upd[0]),
    .bus_req(b_req[0]), .bus_wr(b_wr[0]), .bus_addr(b_addr[0]), .bus_id(b_id[0]),
    .bus_gnt(b_gnt[0]), .bus_done(b_done[0]),
    .snp_vld(s_vld), .snp_wr(s_wr), .snp_addr(s_addr), .snp_id(s_id));

  wt_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .ID_W(DW), .MY_ID(1)) u_peer (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_vld(c_vld[1]), .cpu_req_wr(c_wr[1]), .cpu_req_addr(c_addr[1]),
    .cpu_req_rdy(c_rdy[1]), .cpu_hit(c_hit[1]), .cpu_wr_upd(c_upd[1]),
    .bus_req(b_req[1]), .bus_wr(b_wr[1]), .bus_addr(b_addr[1]), .bus_id(b_id[1]),
    .bus_gnt(b_gnt[1]), .bus_done(b_done[1]),
    .snp_vld(s_vld), .snp_wr(s_wr), .snp_addr(s_addr), .snp_id(s_id));

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // bench line model
  logic       m_v [2][8];
  logic [4:0] m_t [2][8];

  function automatic int b_idx(input logic [AW-1:0] a); return int'(a % 8); endfunction
  function automatic logic [4:0] b_tag(input logic [AW-1:0] a); return 5'(a / 8); endfunction
  function automatic bit model_hit(input int who, input logic [AW-1:0] a);
    return m_v[who][b_idx(a)] && (m_t[who][b_idx(a)] == b_tag(a));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // shared bus model
  bit manual = 1'b0;
  int bm_st = 0, bm_own = 0, bm_cnt = 0;
  int n_txn [2];
  logic          l_wr [2];
  logic [AW-1:0] l_addr[2];
  logic [DW-1:0] l_id [2];

  always @(negedge clk) begin
    if (!manual && rst_n) begin
      case (bm_st)
        0: begin
          if (b_req[0])      begin bm_own = 0; b_gnt[0] = 1'b1; bm_st = 1; end
          else if (b_req[1]) begin bm_own = 1; b_gnt[1] = 1'b1; bm_st = 1; end
        end
        1: begin b_gnt[bm_own] = 1'b0; bm_cnt = LAT; bm_st = 2; end
        2: begin
          if (bm_cnt == 0) begin
            b_done[bm_own] = 1'b1;
            s_vld = 1'b1; s_wr = b_wr[bm_own]; s_addr = b_addr[bm_own]; s_id = b_id[bm_own];
            n_txn[bm_own]++;
            l_wr[bm_own] = b_wr[bm_own]; l_addr[bm_own] = b_addr[bm_own]; l_id[bm_own] = b_id[bm_own];
            bm_st = 3;
          end else bm_cnt--;
        end
        default: begin b_done[bm_own] = 1'b0; s_vld = 1'b0; bm_st = 0; end
      endcase
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clear_model();
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 8; i++) begin m_v[w][i] = 1'b0; m_t[w][i] = '0; end
  endtask

  // one processor operation with full checking against the model
  task automatic do_op(input int who, input bit wr, input logic [AW-1:0] a);
    bit exp_hit, exp_upd, got_hit, got_upd;
    int t0;
    exp_hit = !wr && model_hit(who, a);
    exp_upd = wr && model_hit(who, a);
    t0 = n_txn[who];
    @(negedge clk);
    c_vld[who] = 1'b1; c_wr[who] = wr; c_addr[who] = a;
    forever begin
      #1;
      if (c_rdy[who]) break;
      @(negedge clk);
    end
    got_hit = c_hit[who]; got_upd = c_upd[who];
    @(posedge clk); #1;
    c_vld[who] = 1'b0;
    if (wr) begin
      chk(n_txn[who] == t0 + 1, "R3", "write bus count", n_txn[who] - t0, 1);
      chk(l_wr[who] == 1'b1 && l_addr[who] == a && l_id[who] == DW'(who), "R3", "write txn addr",
          int'(l_addr[who]), int'(a));
      chk(got_upd == exp_upd, exp_upd ? "R5" : "R4", "write update strobe", got_upd, exp_upd);
    end else begin
      chk(got_hit == exp_hit, exp_hit ? "R1" : "R11", "read hit flag", got_hit, exp_hit);
      if (exp_hit)
        chk(n_txn[who] == t0, "R1", "hit bus count", n_txn[who] - t0, 0);
      else
        chk(n_txn[who] == t0 + 1 && l_wr[who] == 1'b0 && l_addr[who] == a, "R2", "miss read txn",
            int'(l_addr[who]), int'(a));
    end
    // model update: fill on read miss, foreign write kills matching line
    if (!wr) begin m_v[who][b_idx(a)] = 1'b1; m_t[who][b_idx(a)] = b_tag(a); end
    else if (model_hit(1 - who, a)) m_v[1 - who][b_idx(a)] = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int w = 0; w < 2; w++) begin
      c_vld[w] = 0; c_wr[w] = 0; c_addr[w] = '0; b_gnt[w] = 0; b_done[w] = 0;
    end
    s_vld = 0; s_wr = 0; s_addr = '0; s_id = '0; bm_st = 0;
    clear_model();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    int seed_v;
    n_txn[0] = 0; n_txn[1] = 0;
    seed_v = int'($urandom(32'h1d5a7c3));
    do_reset();
    @(negedge clk); #1;
    chk(c_rdy[0] == 1'b0 && b_req[0] == 1'b0, "R9", "idle after reset", c_rdy[0], 0);

    // R9: first read after reset misses; R2: second hits
    do_op(0, 0, 8'h0b);
    do_op(0, 0, 8'h0b);
    // R11: same index, other tag misses and replaces
    do_op(0, 0, 8'h13);
    do_op(0, 0, 8'h0b);
    // R4: write to invalid line, then read misses
    do_op(0, 1, 8'h24);
    do_op(0, 0, 8'h24);
    // R5: write hit keeps valid (own snoop ignored, R7)
    do_op(0, 1, 8'h24);
    do_op(0, 0, 8'h24);
    // R6: peer write kills dut line; refetch needed
    do_op(1, 1, 8'h24);
    do_op(0, 0, 8'h24);
    // R6: peer write same index other tag leaves line
    do_op(1, 1, 8'h2c);
    do_op(0, 0, 8'h24);

    // R7: manual own-ID write snoop and foreign read snoop do not kill
    manual = 1'b1;
    @(negedge clk); s_vld = 1; s_wr = 1; s_id = 2'd0; s_addr = 8'h24;
    @(negedge clk); s_wr = 0; s_id = 2'd1;
    @(negedge clk); s_vld = 0;
    manual = 1'b0;
    do_op(0, 0, 8'h24);

    // R8: no completion before grant, early done ignored
    manual = 1'b1;
    @(negedge clk); c_vld[0] = 1; c_wr[0] = 0; c_addr[0] = 8'h35;
    repeat (3) @(negedge clk);
    #1 chk(b_req[0] == 1'b1 && c_rdy[0] == 1'b0, "R8", "waiting for grant", c_rdy[0], 0);
    @(negedge clk); b_done[0] = 1;
    #1 chk(c_rdy[0] == 1'b0, "R8", "done before grant ignored", c_rdy[0], 0);
    @(negedge clk); b_done[0] = 0; b_gnt[0] = 1;
    @(negedge clk); b_gnt[0] = 0;
    #1 chk(c_rdy[0] == 1'b0 && b_req[0] == 1'b0, "R8", "granted, not done", c_rdy[0], 0);
    @(negedge clk); b_done[0] = 1;
    #1 chk(c_rdy[0] == 1'b1 && c_hit[0] == 1'b0, "R8", "completes on done", c_rdy[0], 1);
    @(posedge clk); #1 c_vld[0] = 0; b_done[0] = 0;
    m_v[0][5] = 1'b1; m_t[0][5] = b_tag(8'h35);
    manual = 1'b0;
    do_op(0, 0, 8'h35);

    // R10: kill and hit-read in the same cycle -> miss
    manual = 1'b1;
    @(negedge clk);
    c_vld[0] = 1; c_wr[0] = 0; c_addr[0] = 8'h35;
    s_vld = 1; s_wr = 1; s_id = 2'd1; s_addr = 8'h35;
    #1 chk(c_rdy[0] == 1'b0 && c_hit[0] == 1'b0, "R10", "killed line not hit", c_hit[0], 0);
    @(negedge clk); s_vld = 0; s_wr = 0;
    #1 chk(b_req[0] == 1'b1 && b_wr[0] == 1'b0, "R10", "miss goes to bus", b_req[0], 1);
    manual = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (c_rdy[0]) break;
    end
    @(posedge clk); #1 c_vld[0] = 0;
    chk(l_addr[0] == 8'h35 && l_wr[0] == 1'b0, "R10", "refetch address", int'(l_addr[0]), 'h35);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int who; bit wr; logic [AW-1:0] a;
      who = int'($urandom % 2);
      wr  = ($urandom % 3) == 0;
      a   = {3'b000, 2'($urandom), 3'($urandom)};
      do_op(who, wr, a);
    end

    // R9: reset mid-run clears lines
    do_op(0, 0, 8'h01);
    do_reset();
    do_op(0, 0, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule